// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer

This block is a five-channel pulse-width timer reached through a flat 32-bit register port. Each channel has a down-counter and a comparator. Two shared 8-bit prescalers slow the core clock. A per-channel power-of-two divider then sets the tick that each counter consumes. Software writes a period and a threshold into buffer registers. These values reach the live counter only on a manual load, or on an automatic reload when the count runs out. A running waveform can therefore be retargeted without a glitch.

Channels 0 to 3 each drive one output pin. The raw level is low while the live count is above the threshold and high once the count has fallen to the threshold or below. A per-channel invert bit flips the pin. Channel 4 counts but has no pin. A threshold of all ones keeps the output permanently high.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register reads zero and all four outputs are low.
- R2: Registers sit at byte addresses 0x00 (prescalers), 0x04 (divider selects) and 0x08 (control). The period buffer of channel n is at 0x0C+12n and its threshold buffer is at 0x10+12n. Buffers read back what was written. Any other address reads zero and ignores writes.
- R3: Control bits are packed four per channel. Channel 0 uses bits [3:0] and channel n≥1 uses bits [4(n+1)+3:4(n+1)]. Within a group, offset 0 is run, offset 1 is load, offset 2 is invert and offset 3 is reload. Channel 4 has its reload bit at offset 2 (bit 22) and no invert bit. All other bits read zero, so a write of all ones reads back 0x007FFF0F.
- R4: A running counter decrements once per channel tick. A period buffer value N gives a period of N+1 ticks.
- R5: The raw output is high while the live count is less than or equal to the live threshold. A threshold C below N therefore gives C+1 high ticks per period.
- R6: A threshold of all ones (16 bits at default width) holds the output high for the whole period.
- R7: Setting the invert bit inverts the output pin.
- R8: Prescaler bits [7:0] serve channels 0 and 1, and bits [15:8] serve channels 2 to 4. The prescaled tick rate is the clock rate divided by (field+1).
- R9: Channel n's divider select occupies bits [4n+3:4n]. A select of k divides the prescaled tick by 2^k.
- R10: While a channel's load bit is set, its live counter and threshold copy the buffers every cycle and no counting takes place.
- R11: With reload set, a counter that has reached zero takes the buffered period and threshold on its next tick. A new buffer value therefore takes effect in the following period without a load.
- R12: With reload cleared, the counter stays at zero after it expires and the output holds its level. With run cleared, the counter and output hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | Output pins of channels 0 to 3 |

## Verification
The counters are driven at a full-rate tick, at a tick slowed by the prescaler alone, and at a tick slowed by the divider alone. Comparing the measured period and high time across these three runs separates the prescaler field for each channel group from the divider select. Threshold values are swept across three cases: mid-range, zero and all ones. These distinguish the less-or-equal comparison from an off-by-one one and catch the full-duty case. The invert case mirrors the high time. Sequences with the load bit held, a buffer rewritten while running, reload cleared and run cleared tell apart the four ways the live counter can be updated or frozen.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;
  localparam int NUM_CH  = 5;
  localparam int NUM_PIN = 4;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int PRE_W   = 8;
  localparam int PRE_GRP = 2;
  localparam int SEL_W   = 4;
  localparam int CFG0_W  = PRE_W * PRE_GRP;
  localparam int CFG1_W  = SEL_W * NUM_CH;

  localparam logic [ADDR_W-1:0] A_PRESCALE = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIVSEL   = 8'h04;
  localparam logic [ADDR_W-1:0] A_CONTROL  = 8'h08;

  typedef struct packed {
    logic run;
    logic load;
    logic reload;
  } ch_ctl_t;

  // group position of a channel in the control word (one-group hole after ch 0)
  function automatic int grp_base(int ch);
    return (ch == 0) ? 0 : 4 * (ch + 1);
  endfunction

  function automatic int reload_off(int ch);
    return (ch == NUM_CH - 1) ? 2 : 3;
  endfunction

  function automatic int pre_sel(int ch);
    return (ch < 2) ? 0 : 1;
  endfunction

  function automatic logic [ADDR_W-1:0] period_addr(int ch);
    return ADDR_W'(12 + 12 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] thresh_addr(int ch);
    return ADDR_W'(16 + 12 * ch);
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[grp_base(c)]                 = 1'b1;
      m[grp_base(c) + 1]             = 1'b1;
      m[grp_base(c) + reload_off(c)] = 1'b1;
      if (c < NUM_PIN) m[grp_base(c) + 2] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] div_val,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div_val);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_tick_div.sv
`timescale 1ns/1ps
module pwm_tick_div #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             out_tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] cnt_q, cnt_d, mask;
  logic             cnt_en;

  always_comb begin
    mask     = (DIV_W'(1) << sel) - 1'b1;
    out_tick = in_tick && ((cnt_q & mask) == mask);
    cnt_en   = in_tick;
    cnt_d    = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ch_ctl_t          ctl,
  input  logic [CNT_W-1:0] period_buf,
  input  logic [CNT_W-1:0] thresh_buf,
  output logic [CNT_W-1:0] live_cnt,
  output logic [CNT_W-1:0] live_thr,
  output logic             raw_out
);
  logic [CNT_W-1:0] cnt_q, cnt_d, thr_q, thr_d;
  logic             upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    thr_d  = thr_q;
    upd_en = 1'b0;
    if (ctl.load) begin
      cnt_d  = period_buf;
      thr_d  = thresh_buf;
      upd_en = 1'b1;
    end else if (ctl.run && tick) begin
      if (cnt_q != '0) begin
        cnt_d  = cnt_q - 1'b1;
        upd_en = 1'b1;
      end else if (ctl.reload) begin
        cnt_d  = period_buf;
        thr_d  = thresh_buf;
        upd_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      thr_q <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      thr_q <= thr_d;
    end
  end

  assign live_cnt = cnt_q;
  assign live_thr = thr_q;
  assign raw_out  = (cnt_q <= thr_q);
endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_PIN-1:0] pwm_out
);
  localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

  logic [CFG0_W-1:0] cfg0_q, cfg0_d;
  logic [CFG1_W-1:0] cfg1_q, cfg1_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [NUM_CH-1:0][CNT_W-1:0] period_q, period_d, thresh_q, thresh_d;
  logic cfg0_en, cfg1_en, ctrl_en;
  logic [NUM_CH-1:0] period_en, thresh_en;

  logic [PRE_GRP-1:0] pre_tick;
  logic [NUM_CH-1:0]  ch_tick, ch_run, ch_load, ch_reload, ch_raw;
  logic [NUM_PIN-1:0] ch_inv;
  logic [NUM_CH-1:0][CNT_W-1:0] live_cnt, live_thr;

  // write decode
  always_comb begin
    cfg0_en   = bus_we && (bus_addr == A_PRESCALE);
    cfg1_en   = bus_we && (bus_addr == A_DIVSEL);
    ctrl_en   = bus_we && (bus_addr == A_CONTROL);
    cfg0_d    = bus_wdata[CFG0_W-1:0];
    cfg1_d    = bus_wdata[CFG1_W-1:0];
    ctrl_d    = bus_wdata & CTRL_MASK;
    for (int c = 0; c < NUM_CH; c++) begin
      period_en[c] = bus_we && (bus_addr == period_addr(c));
      thresh_en[c] = bus_we && (bus_addr == thresh_addr(c));
      period_d[c]  = bus_wdata[CNT_W-1:0];
      thresh_d[c]  = bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (cfg0_en) cfg0_q <= cfg0_d;
      if (cfg1_en) cfg1_q <= cfg1_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        period_q[c] <= '0;
        thresh_q[c] <= '0;
      end else begin
        if (period_en[c]) period_q[c] <= period_d[c];
        if (thresh_en[c]) thresh_q[c] <= thresh_d[c];
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_PRESCALE) bus_rdata = DATA_W'(cfg0_q);
    if (bus_addr == A_DIVSEL)   bus_rdata = DATA_W'(cfg1_q);
    if (bus_addr == A_CONTROL)  bus_rdata = ctrl_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == period_addr(c)) bus_rdata = DATA_W'(period_q[c]);
      if (bus_addr == thresh_addr(c)) bus_rdata = DATA_W'(thresh_q[c]);
    end
  end

  for (genvar g = 0; g < PRE_GRP; g++) begin : g_pre
    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_val (cfg0_q[g*PRE_W +: PRE_W]),
      .tick    (pre_tick[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ch_ctl_t ctl;
    assign ch_run[c]    = ctrl_q[grp_base(c)];
    assign ch_load[c]   = ctrl_q[grp_base(c) + 1];
    assign ch_reload[c] = ctrl_q[grp_base(c) + reload_off(c)];
    assign ctl = '{run: ch_run[c], load: ch_load[c], reload: ch_reload[c]};

    pwm_tick_div #(.SEL_W(SEL_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_tick  (pre_tick[pre_sel(c)]),
      .sel      (cfg1_q[c*SEL_W +: SEL_W]),
      .out_tick (ch_tick[c])
    );

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (ch_tick[c]),
      .ctl        (ctl),
      .period_buf (period_q[c]),
      .thresh_buf (thresh_q[c]),
      .live_cnt   (live_cnt[c]),
      .live_thr   (live_thr[c]),
      .raw_out    (ch_raw[c])
    );
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    assign ch_inv[p]  = ctrl_q[grp_base(p) + 2];
    assign pwm_out[p] = ch_raw[p] ^ ch_inv[p];
  end
endmodule

// File: rtl/pwm_timer_checker.sv
`timescale 1ns/1ps
module pwm_timer_checker
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [DATA_W-1:0]           bus_rdata,
  input logic [NUM_PIN-1:0]          pwm_out,
  input logic [NUM_CH-1:0]           ch_tick,
  input logic [NUM_CH-1:0]           ch_run,
  input logic [NUM_CH-1:0]           ch_load,
  input logic [NUM_CH-1:0]           ch_reload,
  input logic [NUM_PIN-1:0]          ch_inv,
  input logic [NUM_CH-1:0][CNT_W-1:0] live_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] live_thr,
  input logic [NUM_CH-1:0][CNT_W-1:0] period_q,
  input logic [NUM_CH-1:0][CNT_W-1:0] thresh_q
);
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h14) |-> (bus_rdata == '0));

  assert_ctrl_holes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CONTROL) |-> (bus_rdata[7:4] == 4'h0 && bus_rdata[DATA_W-1:23] == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[c] && !ch_load[c] && ch_tick[c] && live_cnt[c] != '0)
      |=> (live_cnt[c] == $past(live_cnt[c]) - 1'b1));

    assert_load_copies_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[c] |=> (live_cnt[c] == $past(period_q[c]) && live_thr[c] == $past(thresh_q[c])));

    assert_auto_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[c] && !ch_load[c] && ch_tick[c] && ch_reload[c] && live_cnt[c] == '0)
      |=> (live_cnt[c] == $past(period_q[c]) && live_thr[c] == $past(thresh_q[c])));

    assert_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_load[c] && (!ch_run[c] || (live_cnt[c] == '0 && !ch_reload[c])))
      |=> $stable(live_cnt[c]));
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_p
    assert_full_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (live_thr[p] == '1) |-> (pwm_out[p] == !ch_inv[p]));
  end
endmodule

bind pwm_timer pwm_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .ch_tick   (ch_tick),
  .ch_run    (ch_run),
  .ch_load   (ch_load),
  .ch_reload (ch_reload),
  .ch_inv    (ch_inv),
  .live_cnt  (live_cnt),
  .live_thr  (live_thr),
  .period_q  (period_q),
  .thresh_q  (thresh_q)
);

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] ctl_sh;

  pwm_timer u_pwm_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int gb(input int ch);
    return (ch == 0) ? 0 : 4 * (ch + 1);
  endfunction
  function automatic logic [7:0] a_per(input int ch);
    return 8'(8'h0C + 12 * ch);
  endfunction
  function automatic logic [7:0] a_thr(input int ch);
    return 8'(8'h10 + 12 * ch);
  endfunction

  task automatic do_reset();
    bus_we = 0; bus_addr = 0; bus_wdata = 0; rst_n = 0; ctl_sh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = 8'hFC; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_ctl(input logic [31:0] v);
    ctl_sh = v;
    wr(8'h08, v);
  endtask

  // load with run low, then run + reload with load low
  task automatic start_ch(input int ch, input int per, input int thr);
    wr(a_per(ch), 32'(per));
    wr(a_thr(ch), 32'(thr));
    set_ctl((ctl_sh & ~(32'h1 << gb(ch))) | (32'h2 << gb(ch)));
    set_ctl((ctl_sh & ~(32'h2 << gb(ch))) | (32'h1 << gb(ch)) |
            (32'h1 << (gb(ch) + ((ch == 4) ? 2 : 3))));
  endtask

  task automatic measure(input int ch, output int period, output int highs);
    logic prev;
    bit   found;
    period = -1; highs = -1; found = 0;
    @(negedge clk); prev = pwm_out[ch];
    for (int t = 0; t < 3000 && !found; t++) begin
      @(negedge clk);
      if (pwm_out[ch] && !prev) found = 1;
      prev = pwm_out[ch];
    end
    if (!found) return;
    period = 1; highs = 1; found = 0;
    for (int t = 0; t < 3000 && !found; t++) begin
      @(negedge clk);
      if (pwm_out[ch] && !prev) found = 1;
      else begin
        period++;
        if (pwm_out[ch]) highs++;
      end
      prev = pwm_out[ch];
    end
    if (!found) begin period = -1; highs = -1; end
  endtask

  task automatic hold_level(input string req, input int ch, input int cycles, input logic lvl);
    int bad = 0;
    for (int t = 0; t < cycles; t++) begin
      @(negedge clk);
      if (pwm_out[ch] !== lvl) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(8'h00, d); check("R1 prescale reg", d, 0);
    rd(8'h04, d); check("R1 divsel reg", d, 0);
    rd(8'h08, d); check("R1 control reg", d, 0);
    rd(a_per(3), d); check("R1 period buf ch3", d, 0);
    rd(a_thr(4), d); check("R1 thresh buf ch4", d, 0);
    check("R1 pins low", pwm_out, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    do_reset();
    for (int c = 0; c < 5; c++) begin
      wr(a_per(c), 32'(100 + c));
      wr(a_thr(c), 32'(200 + c));
    end
    for (int c = 0; c < 5; c++) begin
      rd(a_per(c), d); check("R2 period readback", d, 100 + c);
      rd(a_thr(c), d); check("R2 thresh readback", d, 200 + c);
    end
    wr(8'h14, 32'hDEAD_BEEF);
    rd(8'h14, d); check("R2 unused addr 0x14", d, 0);
    rd(8'h44, d); check("R2 unused addr 0x44", d, 0);
    rd(a_per(1), d); check("R2 neighbour untouched", d, 101);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R3 control mask", d, 32'h007F_FF0F);
    check("R3 ch4 reload bit22", d[22], 1);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_basic();
    int p, h;
    do_reset();
    start_ch(0, 9, 3);
    measure(0, p, h);
    check("R4 period N=9", p, 10);
    check("R5 high C=3", h, 4);
    start_ch(3, 6, 0);
    measure(3, p, h);
    check("R4 period N=6 ch3", p, 7);
    check("R5 high C=0 ch3", h, 1);
  endtask

  task automatic t_full();
    do_reset();
    start_ch(1, 5, 32'hFFFF);
    repeat (3) @(negedge clk);
    hold_level("R6 full duty", 1, 30, 1'b1);
  endtask

  task automatic t_invert();
    int p, h;
    do_reset();
    set_ctl(32'h4);
    start_ch(0, 9, 3);
    measure(0, p, h);
    check("R7 inverted period", p, 10);
    check("R7 inverted high", h, 6);
  endtask

  task automatic t_prescale();
    int p, h;
    do_reset();
    wr(8'h00, 32'h0000_0200);
    start_ch(2, 4, 1);
    start_ch(0, 4, 1);
    measure(2, p, h);
    check("R8 ch2 field=2 period", p, 15);
    check("R8 ch2 field=2 high", h, 6);
    measure(0, p, h);
    check("R8 ch0 field=0 period", p, 5);
  endtask

  task automatic t_divider();
    int p, h;
    do_reset();
    wr(8'h04, 32'h0000_0020);
    start_ch(1, 4, 1);
    measure(1, p, h);
    check("R9 ch1 sel=2 period", p, 20);
    check("R9 ch1 sel=2 high", h, 8);
  endtask

  task automatic t_load();
    do_reset();
    wr(a_per(0), 9);
    wr(a_thr(0), 3);
    set_ctl(32'hB);
    hold_level("R10 load freezes low", 0, 20, 1'b0);
    wr(a_thr(0), 32'hFFFF);
    @(negedge clk);
    hold_level("R10 load copies new thresh", 0, 5, 1'b1);
  endtask

  task automatic t_reload();
    int p, h;
    do_reset();
    start_ch(0, 9, 3);
    wr(a_per(0), 14);
    repeat (40) @(negedge clk);
    measure(0, p, h);
    check("R11 new period via reload", p, 15);
    check("R11 high kept", h, 4);
  endtask

  task automatic t_stop();
    logic lvl;
    do_reset();
    start_ch(0, 9, 3);
    set_ctl(ctl_sh & ~32'h8);
    repeat (40) @(negedge clk);
    hold_level("R12 expired holds high", 0, 20, 1'b1);
    start_ch(1, 9, 4);
    repeat (13) @(negedge clk);
    set_ctl(ctl_sh & ~(32'h1 << gb(1)));
    @(negedge clk);
    lvl = pwm_out[1];
    hold_level("R12 run cleared holds", 1, 30, lvl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_regmap();
    t_basic();
    t_full();
    t_invert();
    t_prescale();
    t_divider();
    t_load();
    t_reload();
    t_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule